// File: doc/BRIEF.md
# Eight-Level Rotating-Priority Interrupt Controller

This block collects eight interrupt request lines on behalf of a CPU and tells the CPU when one of them needs attention. It keeps three 8-bit registers, each with one bit per level: pending requests, mask and in-service. A resolver ranks the levels on a rotating ring. It raises `int_out` when an unmasked pending request outranks every level that is currently in service. Because of this rule, a service routine can be interrupted by a more urgent level but not by a less urgent one.

The CPU answers `int_out` with two acknowledge pulses. The first pulse picks the winning level and moves it from pending to in-service. The second pulse returns an 8-bit vector that combines a programmed base with the level number. Levels leave in-service in one of two ways. In automatic mode they are cleared on the second pulse. Otherwise a command clears them, either naming a level or taking the most urgent one. The ranking ring can be turned in three ways: by setting its bottom level directly, through an end-of-interrupt command, or automatically after each service. All configuration goes through a write port with four addresses. A registered read port returns any of the registers.

Top module: `prio_intc`

## Requirements
- R1: After reset the pending, mask and in-service registers are all zero, `int_out` and `vec_valid` are low, and level 0 ranks highest with level 7 lowest.
- R2: `status_out` shows, one cycle after `rd_sel` is applied, the pending register (`rd_sel`=0), the mask (1), the in-service register (2), or the vector base in bits [7:3] (3).
- R3: Each level has a rank, with 0 being the most urgent. A level's rank is (level − bottom − 1) mod 8, where bottom is the least urgent level. `int_out` rises when an unmasked request exists and no level is in service.
- R4: On the first acknowledge pulse, the most urgent eligible request gets its in-service bit set and its pending bit cleared. `vec_valid` stays low.
- R5: On the second acknowledge pulse, `vec_out` carries {base[4:0], level[2:0]} with `vec_valid` high for exactly one cycle. Writing address 1 stores the base from data bits [7:3].
- R6: An in-service level suppresses `int_out` for requests of equal or lower urgency. A strictly more urgent request still raises `int_out`.
- R7: When mode bit 0 (address 2) is set, the serviced level's in-service bit is cleared by the second acknowledge pulse.
- R8: A command is a write to address 3 with the opcode in bits [7:5] and the level in bits [2:0]. Opcode 1 clears the most urgent in-service bit. Opcode 2 clears the bit of the named level.
- R9: Opcode 4 makes the named level the bottom, so the level after it becomes the most urgent.
- R10: Opcode 3 works like opcode 1 and also makes the cleared level the bottom. Opcode 5 works like opcode 2 and also makes the named level the bottom. When mode bits 1 and 0 are both set, each level serviced with automatic clearing becomes the bottom.
- R11: Writing address 0 stores the mask from data bits [7:0]. A set bit blocks only its own level; requests on other levels are handled as before.
- R12: If the request has gone away by the first acknowledge pulse, the vector reports level 7 and no in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Level-sensitive request lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mask, 1 base, 2 mode, 3 command |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Status selection |
| status_out | output | 8 | Registered status value |
| ack_in | input | 1 | Acknowledge pulse, one cycle per pulse |
| int_out | output | 1 | Interrupt to the CPU |
| vec_out | output | 8 | Vector, zero outside the second acknowledge |
| vec_valid | output | 1 | Vector qualifier |

## Verification
The assertions assume that the CPU never issues a command write in the same cycle as an acknowledge pulse. They also assume that acknowledge pulses come strictly in pairs and last one cycle each. The stimulus keeps to this by driving writes and pulses from separate, serial tasks. It also holds `irq_in` steady from before the first pulse until the vector has been read, except in the deliberate case where a request is withdrawn.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int OP_W = 3;

  typedef enum logic [1:0] {
    WA_MASK = 2'd0,
    WA_BASE = 2'd1,
    WA_MODE = 2'd2,
    WA_CMD  = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    RS_PEND = 2'd0,
    RS_MASK = 2'd1,
    RS_SERV = 2'd2,
    RS_BASE = 2'd3
  } rd_sel_e;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 3'd0,
    OP_NS_EOI  = 3'd1,
    OP_SP_EOI  = 3'd2,
    OP_NS_ROT  = 3'd3,
    OP_SET_BOT = 3'd4,
    OP_SP_ROT  = 3'd5
  } cmd_op_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] bot,
  output logic          hit,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  logic [LW-1:0] idx;

  // Scan from the least urgent slot down so the most urgent set bit wins.
  always_comb begin
    hit  = 1'b0;
    lvl  = '0;
    rank = '0;
    idx  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = bot + LW'(k) + LW'(1);
      if (vec[idx]) begin
        hit  = 1'b1;
        lvl  = idx;
        rank = LW'(k);
      end
    end
  end
endmodule

// File: rtl/intc_cmd.sv
module intc_cmd
  import intc_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic          cmd_we,
  input  logic [OP_W-1:0] op_raw,
  input  logic [LW-1:0] op_lvl,
  input  logic          isr_hit,
  input  logic [LW-1:0] isr_lvl,
  output logic [N-1:0]  eoi_clr,
  output logic          rot_en,
  output logic [LW-1:0] rot_lvl
);
  cmd_op_e op;
  assign op = cmd_op_e'(op_raw);

  always_comb begin
    eoi_clr = '0;
    rot_en  = 1'b0;
    rot_lvl = op_lvl;
    if (cmd_we) begin
      case (op)
        OP_NS_EOI: begin
          if (isr_hit) eoi_clr = N'(1) << isr_lvl;
        end
        OP_NS_ROT: begin
          if (isr_hit) eoi_clr = N'(1) << isr_lvl;
          rot_en  = isr_hit;
          rot_lvl = isr_lvl;
        end
        OP_SP_EOI: eoi_clr = N'(1) << op_lvl;
        OP_SP_ROT: begin
          eoi_clr = N'(1) << op_lvl;
          rot_en  = 1'b1;
        end
        OP_SET_BOT: rot_en = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_LVL     = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] irq_in,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [1:0]         rd_sel,
  output logic [DATA_W-1:0]  status_out,
  input  logic               ack_in,
  output logic               int_out,
  output logic [DATA_W-1:0]  vec_out,
  output logic               vec_valid
);
  localparam int LVL_W  = $clog2(NUM_LVL);
  localparam int BASE_W = DATA_W - LVL_W;

  logic [NUM_LVL-1:0] req_s, irr_q, imr_q, isr_q;
  logic [LVL_W-1:0]   bot_q, lvl_q;
  logic [BASE_W-1:0]  base_q;
  logic               aeoi_q, arot_q, phase_q, served_q, int_q, vec_vld_q;
  logic [DATA_W-1:0]  vec_q, stat_q;

  intc_sync #(.W(NUM_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(req_s)
  );

  // Ranking of eligible requests and of in-service levels on the same ring.
  logic               req_hit, isr_hit;
  logic [LVL_W-1:0]   req_lvl, req_rank, isr_lvl, isr_rank;

  intc_resolver #(.N(NUM_LVL), .LW(LVL_W)) u_req_res (
    .vec(irr_q & ~imr_q), .bot(bot_q),
    .hit(req_hit), .lvl(req_lvl), .rank(req_rank)
  );

  intc_resolver #(.N(NUM_LVL), .LW(LVL_W)) u_isr_res (
    .vec(isr_q), .bot(bot_q),
    .hit(isr_hit), .lvl(isr_lvl), .rank(isr_rank)
  );

  logic int_c;
  assign int_c = req_hit && (!isr_hit || (req_rank < isr_rank));

  // Command decode.
  logic               cmd_we, rot_en;
  logic [NUM_LVL-1:0] eoi_clr;
  logic [LVL_W-1:0]   rot_lvl;
  assign cmd_we = wr_en && (wr_sel_e'(wr_addr) == WA_CMD);

  intc_cmd #(.N(NUM_LVL), .LW(LVL_W)) u_cmd (
    .cmd_we(cmd_we), .op_raw(wr_data[DATA_W-1 -: OP_W]),
    .op_lvl(wr_data[LVL_W-1:0]),
    .isr_hit(isr_hit), .isr_lvl(isr_lvl),
    .eoi_clr(eoi_clr), .rot_en(rot_en), .rot_lvl(rot_lvl)
  );

  // Acknowledge handshake.
  logic               ack1, ack2, auto_rot;
  logic [NUM_LVL-1:0] ack_set, auto_clr;
  assign ack1     = ack_in && !phase_q;
  assign ack2     = ack_in && phase_q;
  assign ack_set  = (ack1 && int_c) ? (NUM_LVL'(1) << req_lvl) : '0;
  assign auto_clr = (ack2 && aeoi_q && served_q) ? (NUM_LVL'(1) << lvl_q) : '0;
  assign auto_rot = ack2 && aeoi_q && arot_q && served_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q     <= '0;
      imr_q     <= '0;
      isr_q     <= '0;
      bot_q     <= '1;
      base_q    <= '0;
      aeoi_q    <= 1'b0;
      arot_q    <= 1'b0;
      phase_q   <= 1'b0;
      lvl_q     <= '0;
      served_q  <= 1'b0;
      vec_q     <= '0;
      vec_vld_q <= 1'b0;
      int_q     <= 1'b0;
      stat_q    <= '0;
    end else begin
      irr_q <= req_s & ~ack_set;
      isr_q <= (isr_q | ack_set) & ~(eoi_clr | auto_clr);

      if (wr_en) begin
        case (wr_sel_e'(wr_addr))
          WA_MASK: imr_q  <= wr_data[NUM_LVL-1:0];
          WA_BASE: base_q <= wr_data[DATA_W-1:LVL_W];
          WA_MODE: begin
            aeoi_q <= wr_data[0];
            arot_q <= wr_data[1];
          end
          default: ;
        endcase
      end

      if (rot_en)        bot_q <= rot_lvl;
      else if (auto_rot) bot_q <= lvl_q;

      vec_q     <= '0;
      vec_vld_q <= 1'b0;
      if (ack1) begin
        phase_q  <= 1'b1;
        lvl_q    <= int_c ? req_lvl : '1;
        served_q <= int_c;
      end else if (ack2) begin
        phase_q   <= 1'b0;
        vec_q     <= {base_q, lvl_q};
        vec_vld_q <= 1'b1;
      end

      int_q <= int_c;

      case (rd_sel_e'(rd_sel))
        RS_PEND: stat_q <= DATA_W'(irr_q);
        RS_MASK: stat_q <= DATA_W'(imr_q);
        RS_SERV: stat_q <= DATA_W'(isr_q);
        default: stat_q <= {base_q, {LVL_W{1'b0}}};
      endcase
    end
  end

  assign status_out = stat_q;
  assign int_out    = int_q;
  assign vec_out    = vec_q;
  assign vec_valid  = vec_vld_q;

  AST_VEC_ON_SECOND: assert property (@(posedge clk) disable iff (rst)
    vec_vld_q |-> $past(ack_in && phase_q)); // R5
  AST_NO_DATA_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ack_in && !phase_q) |=> !vec_vld_q); // R4
  AST_SERVE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ack_in && !phase_q && int_c && !wr_en) |=> isr_q[$past(req_lvl)] && !irr_q[$past(req_lvl)]); // R4
  AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (rst)
    req_hit |-> !imr_q[req_lvl]); // R11
  AST_SPEC_EOI: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && wr_data[DATA_W-1 -: OP_W] == OP_SP_EOI && !ack_in)
      |=> !isr_q[$past(wr_data[LVL_W-1:0])]); // R8
  AST_AUTO_EOI: assert property (@(posedge clk) disable iff (rst)
    (ack_in && phase_q && aeoi_q && served_q && !wr_en) |=> !isr_q[$past(lvl_q)]); // R7
  AST_SET_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && wr_data[DATA_W-1 -: OP_W] == OP_SET_BOT)
      |=> bot_q == $past(wr_data[LVL_W-1:0])); // R9
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] status_out;
  logic       ack_in = 1'b0;
  logic       int_out;
  logic [7:0] vec_out;
  logic       vec_valid;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] m_imr = '0, m_isr = '0;
  logic [4:0] m_base = '0;
  int         m_bot = 7;
  bit         m_aeoi = 0, m_arot = 0;

  always #5 clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_sel(rd_sel), .status_out(status_out), .ack_in(ack_in),
    .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  function automatic int pick(input logic [7:0] v, input int b);
    for (int k = 0; k < 8; k++) begin
      int idx = (b + 1 + k) % 8;
      if (v[idx]) return idx;
    end
    return -1;
  endfunction

  function automatic int rank_of(input int l, input int b);
    return (l - b - 1 + 16) % 8;
  endfunction

  function automatic bit exp_int();
    int r = pick(irq_in & ~m_imr, m_bot);
    int s = pick(m_isr, m_bot);
    if (r < 0) return 0;
    if (s < 0) return 1;
    return rank_of(r, m_bot) < rank_of(s, m_bot);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic status(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s;
    repeat (2) @(negedge clk);
    v = status_out;
  endtask

  task automatic chk_stat(input string tag, input logic [1:0] s, input logic [7:0] e);
    logic [7:0] v;
    status(s, v);
    chk(tag, v, e);
  endtask

  task automatic cmd(input int op, input int l);
    int s;
    wr(2'd3, {3'(op), 2'b00, 3'(l)});
    case (op)
      1, 3: begin
        s = pick(m_isr, m_bot);
        if (s >= 0) begin
          m_isr[s] = 1'b0;
          if (op == 3) m_bot = s;
        end
      end
      2: m_isr[l] = 1'b0;
      5: begin m_isr[l] = 1'b0; m_bot = l; end
      4: m_bot = l;
      default: ;
    endcase
  endtask

  task automatic do_ack(input int l, input bit served, input string tag);
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    chk({tag, " R4 no vector on first ack"}, vec_valid, 1'b0);
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    chk({tag, " R5 vector valid"}, vec_valid, 1'b1);
    chk({tag, " R5 vector value"}, vec_out, {m_base, 3'(l)});
    if (served) begin
      if (!m_aeoi) m_isr[l] = 1'b1;
      else if (m_arot) m_bot = l;
    end
    @(negedge clk);
    chk({tag, " R5 vector one cycle"}, vec_valid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 int low", int_out, 1'b0);
    chk("R1 vec_valid low", vec_valid, 1'b0);
    chk_stat("R1 pending zero", 2'd0, 8'h00);
    chk_stat("R1 mask zero", 2'd1, 8'h00);
    chk_stat("R1 in-service zero", 2'd2, 8'h00);

    wr(2'd1, 8'hA8); m_base = 5'h15;
    chk_stat("R2 base readback", 2'd3, 8'hA8);

    // R3 default order, level 5 beats 7
    irq_in = 8'hA0; settle();
    chk("R3 int raised", int_out, 1'b1);
    chk_stat("R2 pending readback", 2'd0, 8'hA0);
    do_ack(5, 1, "R3");
    chk_stat("R4 in-service after ack", 2'd2, 8'h20);
    settle();
    chk("R6 lower blocked by in-service", int_out, 1'b0);
    irq_in = 8'hA4; settle();
    chk("R6 higher still raises int", int_out, 1'b1);
    do_ack(2, 1, "R6");
    chk_stat("R6 nested in-service", 2'd2, 8'h24);

    cmd(1, 0);
    chk_stat("R8 non-specific clears most urgent", 2'd2, 8'h20);
    cmd(2, 5);
    chk_stat("R8 specific clears named", 2'd2, 8'h00);

    // R11 mask only its own level
    wr(2'd0, 8'h04); m_imr = 8'h04;
    irq_in = 8'h84; settle();
    chk("R11 unmasked level still raises int", int_out, 1'b1);
    do_ack(7, 1, "R11");
    chk_stat("R11 mask readback", 2'd1, 8'h04);
    cmd(2, 7);
    wr(2'd0, 8'h00); m_imr = 8'h00;

    // R9 bottom at 5
    cmd(4, 5);
    irq_in = 8'h50; settle();
    do_ack(6, 1, "R9 level 6 above 4");
    cmd(2, 6);
    irq_in = 8'h11; settle();
    do_ack(0, 1, "R9 level 0 above 4");
    cmd(3, 0);
    chk_stat("R10 rotate eoi clears", 2'd2, 8'h00);
    irq_in = 8'h03; settle();
    do_ack(1, 1, "R10 level 0 now bottom");
    cmd(1, 0);

    // R7 automatic clearing
    wr(2'd2, 8'h01); m_aeoi = 1;
    settle();
    do_ack(1, 1, "R7");
    chk_stat("R7 in-service cleared", 2'd2, 8'h00);
    wr(2'd2, 8'h03); m_arot = 1;
    irq_in = 8'h06; settle();
    do_ack(1, 1, "R10 auto rotate first");
    settle();
    chk("R10 int after auto rotate", int_out, 1'b1);
    do_ack(2, 1, "R10 auto rotate second");
    wr(2'd2, 8'h00); m_aeoi = 0; m_arot = 0;
    cmd(4, 7);

    // R12 request withdrawn
    irq_in = 8'h08; settle();
    chk("R12 int before withdraw", int_out, 1'b1);
    irq_in = 8'h00; settle();
    do_ack(7, 0, "R12");
    chk_stat("R12 no in-service set", 2'd2, 8'h00);

    // Random phase
    void'($urandom(32'd1234));
    for (int it = 0; it < 300; it++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) begin
        logic [7:0] mk = 8'($urandom);
        wr(2'd0, mk); m_imr = mk;
      end else if (r == 1) begin
        int md = $urandom_range(0, 3);
        wr(2'd2, 8'(md)); m_aeoi = md[0]; m_arot = md[1];
      end
      irq_in = 8'($urandom);
      settle();
      chk("R6 random int level", int_out, exp_int());
      if (exp_int()) do_ack(pick(irq_in & ~m_imr, m_bot), 1, "R3 random");
      if ($urandom_range(0, 2) != 0) begin
        int ops [5] = '{1, 2, 3, 4, 5};
        cmd(ops[$urandom_range(0, 4)], $urandom_range(0, 7));
      end
      if (it % 10 == 0) chk_stat("R8 random in-service", 2'd2, m_isr);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule